// File: doc/BRIEF.md
# Debug Probe Capture and Readout

This block acts as a small logic analyzer built into a design. Several probe slots each watch a record made of an FSM state code, a 32-bit address and an 8-bit data value. Every slot keeps a rolling history of the last 32 records. A new record enters on every design clock, and the oldest one drops out.

A host reads a slot through a byte-stream link. It sends one byte that names the slot. The block then freezes that slot's history into a holding register and pulses a per-slot read-enable back into the design. It then streams the frozen history out as 192 bytes. The bytes travel through an asynchronous FIFO into the serial clock domain.

Both byte ports use valid/ready handshakes. The receive side always reports ready; a byte that cannot be acted on is consumed and discarded. The transmit side presents a byte while valid is high and holds that byte unchanged until ready is seen high on a clock edge. It never drops or repeats a byte under back-pressure.

Top module: `dbgp_probe_top`

## Requirements
- R1: Each slot's history holds the last 32 records. The newest record enters on every design clock at which reset is inactive, and the record that was 32 clocks old is discarded.
- R2: A record consists of an 8-bit state code, a 32-bit address and an 8-bit data value. Slot n takes these from bits [8n+7:8n] of `probe_st`, bits [32n+31:32n] of `probe_ad` and bits [8n+7:8n] of `probe_dt`.
- R3: A received byte of value 0 to 3 selects the slot with that index. A byte of 4 or above produces no read-enable pulse and no transmitted byte.
- R4: Each accepted selection raises bit n of `probe_taken` for exactly one design clock cycle, where n is the selected slot. No other bit of `probe_taken` rises.
- R5: The transmitted snapshot equals the selected slot's history as it stood in the cycle where `probe_taken` was high. Capture continues during the transfer and does not change bytes that are already frozen.
- R6: A snapshot is 192 bytes long. Records are sent from oldest to newest. Each record is sent as the state byte, then the four address bytes with the least significant byte first, then the data byte.
- R7: From the acceptance of a selection until the handshake of the 192nd byte, every received byte is discarded. After that handshake, a new selection is accepted.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable. Every byte of a snapshot is delivered exactly once, whatever the pattern of `tx_ready`.
- R9: After reset, every history entry is zero, `probe_taken` and `tx_valid` are low, and the block waits for a selection byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock: capture, snapshot, FIFO write side |
| rst_n | input | 1 | Active-low reset, design domain |
| ser_clk | input | 1 | Serial-link clock: selection, FIFO read side |
| ser_rst_n | input | 1 | Active-low reset, serial domain |
| probe_st | input | 32 | State codes, 8 bits per slot |
| probe_ad | input | 128 | Addresses, 32 bits per slot |
| probe_dt | input | 32 | Data values, 8 bits per slot |
| probe_taken | output | 4 | One-cycle read-enable pulse per slot |
| rx_valid | input | 1 | Selection byte valid |
| rx_data | input | 8 | Selection byte (slot index) |
| rx_ready | output | 1 | Always high; bytes that cannot be used are discarded |
| tx_valid | output | 1 | Snapshot byte valid |
| tx_data | output | 8 | Snapshot byte |
| tx_ready | input | 1 | Downstream accepts the byte at this edge |

## Verification
A selection byte is accepted on the serial edge that samples it. The toggle that carries it needs two design-clock edges to pass the synchronizer, so `probe_taken` rises two to three design cycles later. The snapshot is frozen at the end of that same cycle.

The first snapshot byte reaches `tx_valid` a few serial cycles after the first FIFO write, once the write pointer has crossed. The remaining bytes follow at the rate that `tx_ready` allows.

The bench does not assume any fixed distance between the clock domains. It samples the design outputs on falling edges and logs a pulse in the cycle where it is seen, copying its own history model at that point. It waits for the full byte count within a bounded window and then waits a further quiet interval, so that a missing, extra or late byte or pulse is caught.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int ST_W      = 8;
  localparam int AD_W      = 32;
  localparam int DT_W      = 8;
  localparam int AD_BYTES  = AD_W / 8;
  localparam int REC_BYTES = 2 + AD_BYTES;

  typedef struct packed {
    logic [ST_W-1:0] st;
    logic [AD_W-1:0] ad;
    logic [DT_W-1:0] dt;
  } rec_t;

  // byte k of a record on the wire: state, address LSB first, data
  function automatic logic [7:0] rec_byte(rec_t r, int unsigned k);
    if (k == 0) return r.st;
    if (k <= AD_BYTES) return r.ad[8*(k-1) +: 8];
    return r.dt;
  endfunction
endpackage

// File: rtl/dbgp_history.sv
module dbgp_history import dbgp_pkg::*; #(
  parameter int NUM_PROBES = 4,
  parameter int DEPTH      = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  rec_t din  [NUM_PROBES],
  output rec_t hist [NUM_PROBES][DEPTH]
);
  for (genvar p = 0; p < NUM_PROBES; p++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) hist[p][i] <= '0;
      end else begin
        hist[p][0] <= din[p];
        for (int i = 1; i < DEPTH; i++) hist[p][i] <= hist[p][i-1];
      end
    end

    // R1: the entry behind the newest is the previous newest
    a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> hist[p][1] == $past(hist[p][0]));
    // R1: the oldest entry is the one before it a cycle ago
    a_r1_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> hist[p][DEPTH-1] == $past(hist[p][DEPTH-2]));
  end
endmodule

// File: rtl/dbgp_afifo.sv
module dbgp_afifo #(
  parameter int AW = 4
) (
  input  logic       wclk,
  input  logic       wrst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       full,
  input  logic       rclk,
  input  logic       rrst_n,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       empty
);
  localparam int NENT = 1 << AW;

  logic [7:0]  mem [NENT];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] wq1, wq2, rq1, rq2;
  logic [AW:0] wbin_n, rbin_n;
  logic        push, pop;

  assign push   = wr_en && !full;
  assign pop    = rd_en && !empty;
  assign wbin_n = wbin + {{AW{1'b0}}, push};
  assign rbin_n = rbin + {{AW{1'b0}}, pop};

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
      wq1   <= rgray;
      wq2   <= wq1;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
      rq1   <= wgray;
      rq2   <= rq1;
    end
  end

  assign full    = (wgray == {~wq2[AW:AW-1], wq2[AW-2:0]});
  assign empty   = (rgray == rq2);
  assign rd_data = mem[rbin[AW-1:0]];

  // R8: a byte on offer stays on offer and unchanged until taken
  a_r8_hold_out: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!empty && !rd_en) |=> (!empty && $stable(rd_data)));
  // R8: no write is attempted into a full buffer
  a_r8_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> !wr_en);
endmodule

// File: rtl/dbgp_host_ctrl.sv
module dbgp_host_ctrl #(
  parameter int NUM_PROBES = 4,
  parameter int TOTAL      = 192,
  parameter int IDW        = 2
) (
  input  logic           ser_clk,
  input  logic           ser_rst_n,
  input  logic           rx_valid,
  input  logic [7:0]     rx_data,
  output logic           rx_ready,
  input  logic           tx_fire,
  output logic           req_tgl,
  output logic [IDW-1:0] req_id
);
  localparam int          CW   = $clog2(TOTAL);
  localparam logic [7:0]  NP8  = 8'(NUM_PROBES);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic          busy;
  logic [CW-1:0] sent;
  logic          take_id;

  assign rx_ready = 1'b1;
  assign take_id  = rx_valid && !busy && (rx_data < NP8);

  always_ff @(posedge ser_clk or negedge ser_rst_n) begin
    if (!ser_rst_n) begin
      busy    <= 1'b0;
      sent    <= '0;
      req_tgl <= 1'b0;
      req_id  <= '0;
    end else if (take_id) begin
      busy    <= 1'b1;
      sent    <= '0;
      req_tgl <= ~req_tgl;
      req_id  <= rx_data[IDW-1:0];
    end else if (busy && tx_fire) begin
      if (sent == LAST) busy <= 1'b0;
      else              sent <= sent + 1'b1;
    end
  end

  // R3: an out-of-range index starts nothing
  a_r3_ignore_bad: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    (rx_valid && !busy && rx_data >= NP8) |=> (!busy && $stable(req_tgl)));
  // R7: no new request while a snapshot is still being delivered
  a_r7_hold_busy: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    (busy && !tx_fire) |=> (busy && $stable(req_tgl) && $stable(req_id)));
endmodule

// File: rtl/dbgp_snap_stream.sv
module dbgp_snap_stream import dbgp_pkg::*; #(
  parameter int NUM_PROBES = 4,
  parameter int DEPTH      = 32,
  parameter int IDW        = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_tgl,
  input  logic [IDW-1:0]        req_id,
  input  rec_t                  hist [NUM_PROBES][DEPTH],
  output logic [NUM_PROBES-1:0] take,
  output logic                  wr_en,
  output logic [7:0]            wr_byte,
  input  logic                  full
);
  localparam int            SW    = $clog2(DEPTH);
  localparam int            BW    = $clog2(REC_BYTES);
  localparam logic [SW-1:0] S_TOP = SW'(DEPTH - 1);
  localparam logic [BW-1:0] B_TOP = BW'(REC_BYTES - 1);

  logic          s1, s2, s3, fire;
  logic          active;
  logic [SW-1:0] smp;
  logic [BW-1:0] bsel;
  logic          last_byte;
  rec_t          snap [DEPTH];
  rec_t          cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= req_tgl; s2 <= s1; s3 <= s2;
    end
  end
  assign fire = s2 ^ s3;

  for (genvar p = 0; p < NUM_PROBES; p++) begin : g_take
    assign take[p] = fire && (req_id == IDW'(p));
  end

  always_ff @(posedge clk) begin
    if (fire) snap <= hist[req_id];
  end

  assign last_byte = (smp == S_TOP) && (bsel == B_TOP);
  assign wr_en     = active && !full;
  assign cur       = snap[S_TOP - smp];
  assign wr_byte   = rec_byte(cur, int'(bsel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; smp <= '0; bsel <= '0;
    end else if (fire) begin
      active <= 1'b1; smp <= '0; bsel <= '0;
    end else if (wr_en) begin
      if (last_byte) active <= 1'b0;
      if (bsel == B_TOP) begin
        bsel <= '0;
        smp  <= smp + 1'b1;
      end else begin
        bsel <= bsel + 1'b1;
      end
    end
  end

  // R4: a read-enable pulse lasts exactly one cycle
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|take) |=> !(|take));
  // R7: a new request never lands on a transfer in progress
  a_r7_idle_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !active);
  // R6: the transfer ends right after its final byte
  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && last_byte) |=> !active);
endmodule

// File: rtl/dbgp_probe_top.sv
module dbgp_probe_top import dbgp_pkg::*; #(
  parameter int NUM_PROBES = 4,
  parameter int DEPTH      = 32,
  parameter int FIFO_AW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_rst_n,
  input  logic [NUM_PROBES*ST_W-1:0] probe_st,
  input  logic [NUM_PROBES*AD_W-1:0] probe_ad,
  input  logic [NUM_PROBES*DT_W-1:0] probe_dt,
  output logic [NUM_PROBES-1:0]      probe_taken,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  output logic                       rx_ready,
  output logic                       tx_valid,
  output logic [7:0]                 tx_data,
  input  logic                       tx_ready
);
  localparam int IDW   = $clog2(NUM_PROBES);
  localparam int TOTAL = DEPTH * REC_BYTES;

  rec_t           din  [NUM_PROBES];
  rec_t           hist [NUM_PROBES][DEPTH];
  logic           req_tgl;
  logic [IDW-1:0] req_id;
  logic           wr_en, full, empty, tx_fire;
  logic [7:0]     wr_byte;

  for (genvar p = 0; p < NUM_PROBES; p++) begin : g_in
    assign din[p] = {probe_st[p*ST_W +: ST_W], probe_ad[p*AD_W +: AD_W],
                     probe_dt[p*DT_W +: DT_W]};
  end

  dbgp_history #(.NUM_PROBES(NUM_PROBES), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .din(din), .hist(hist));

  dbgp_host_ctrl #(.NUM_PROBES(NUM_PROBES), .TOTAL(TOTAL), .IDW(IDW)) u_host (
    .ser_clk(ser_clk), .ser_rst_n(ser_rst_n), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_fire(tx_fire),
    .req_tgl(req_tgl), .req_id(req_id));

  dbgp_snap_stream #(.NUM_PROBES(NUM_PROBES), .DEPTH(DEPTH), .IDW(IDW)) u_snap (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .req_id(req_id),
    .hist(hist), .take(probe_taken), .wr_en(wr_en), .wr_byte(wr_byte),
    .full(full));

  dbgp_afifo #(.AW(FIFO_AW)) u_fifo (
    .wclk(clk), .wrst_n(rst_n), .wr_en(wr_en), .wr_data(wr_byte), .full(full),
    .rclk(ser_clk), .rrst_n(ser_rst_n), .rd_en(tx_fire), .rd_data(tx_data),
    .empty(empty));

  assign tx_valid = !empty;
  assign tx_fire  = tx_valid && tx_ready;

  // R4: at most one slot is read per pulse
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_taken));
endmodule

// File: tb/dbgp_probe_top_tb.sv
module dbgp_probe_top_tb;
  localparam int NP = 4, DEPTH = 32, RB = 6, TOTAL = DEPTH * RB;
  // stimulus table: {slot byte, throttle, response expected}
  localparam logic [9:0] VEC [8] = '{
    {8'd2, 1'b0, 1'b1}, {8'd3, 1'b1, 1'b1}, {8'd5, 1'b0, 1'b0},
    {8'd1, 1'b1, 1'b1}, {8'd4, 1'b0, 1'b0}, {8'd0, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b0}, {8'd2, 1'b1, 1'b1}};

  logic clk = 0, ser_clk = 0;
  always #2 clk = ~clk;
  always #3 ser_clk = ~ser_clk;

  logic rst_n = 0, ser_rst_n = 0;
  logic [NP*8-1:0]  p_st = '0;
  logic [NP*32-1:0] p_ad = '0;
  logic [NP*8-1:0]  p_dt = '0;
  logic [NP-1:0]    taken;
  logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic [7:0] rx_data = 0, tx_data;

  int n_checks = 0, n_fail = 0;
  logic [47:0] mdl [NP][DEPTH];
  logic [47:0] snap_mdl [NP][DEPTH];
  int pulses [NP];
  int k_cyc = 0, got_n = 0, thr = 0, rcyc = 0;
  logic [7:0] got [256];
  bit done = 0;

  dbgp_probe_top u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
    .probe_st(p_st), .probe_ad(p_ad), .probe_dt(p_dt), .probe_taken(taken),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

  function automatic logic [47:0] pat(int s, int k);
    return {8'(k * 5 + s * 17), (32'(k) * 32'h01030507) ^ {8'(s), 24'h0},
            8'((k * 3) ^ s)};
  endfunction

  initial for (int s = 0; s < NP; s++) begin
    pulses[s] = 0;
    for (int i = 0; i < DEPTH; i++) begin mdl[s][i] = '0; snap_mdl[s][i] = '0; end
  end

  // design side: log pulses, freeze model, drive next record (R1, R2, R5)
  always @(negedge clk) begin
    for (int s = 0; s < NP; s++) if (taken[s]) begin
      pulses[s]++;
      for (int i = 0; i < DEPTH; i++) snap_mdl[s][i] = mdl[s][i];
    end
    k_cyc++;
    for (int s = 0; s < NP; s++) begin
      logic [47:0] v;
      v = pat(s, k_cyc);
      p_st[s*8 +: 8]   = v[47:40];
      p_ad[s*32 +: 32] = v[39:8];
      p_dt[s*8 +: 8]   = v[7:0];
      if (!rst_n) for (int i = 0; i < DEPTH; i++) mdl[s][i] = '0;
      else begin
        for (int i = DEPTH - 1; i > 0; i--) mdl[s][i] = mdl[s][i-1];
        mdl[s][0] = v;
      end
    end
  end

  // serial sink with optional back-pressure (R8)
  always @(negedge ser_clk) begin
    rcyc++;
    tx_ready = (thr == 0) ? 1'b1 : (rcyc % 3 != 0);
    if (tx_valid && tx_ready) begin
      if (got_n < 256) got[got_n] = tx_data;
      got_n++;
    end
  end

  function automatic logic [7:0] exp_byte(int s, int j);
    logic [47:0] r;
    int k;
    r = snap_mdl[s][DEPTH - 1 - j / RB];
    k = j % RB;
    if (k == 0) return r[47:40];
    if (k == RB - 1) return r[7:0];
    return r[8 + 8 * (k - 1) +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_id(input logic [7:0] b);
    @(negedge ser_clk); rx_valid = 1; rx_data = b;
    @(negedge ser_clk); rx_valid = 0;
  endtask

  task automatic check_bytes(input int s, input string req);
    int mism = 0, fj = 0, fa = 0, fe = 0;
    for (int j = 0; j < TOTAL; j++) if (got[j] !== exp_byte(s, j)) begin
      if (mism == 0) begin fj = j; fa = got[j]; fe = exp_byte(s, j); end
      mism++;
    end
    chk(mism == 0, req, $sformatf("snapshot bytes, %0d wrong, first at %0d", mism, fj),
        fa, fe);
  endtask

  task automatic check_pulses(input int p0 [NP], input int sel, input string req);
    int bad = 0;
    for (int s = 0; s < NP; s++)
      if (pulses[s] - p0[s] != ((s == sel) ? 1 : 0)) bad++;
    chk(bad == 0, req, "slots with wrong read-enable pulse count", bad, 0);
  endtask

  task automatic wait_bytes();
    int wt = 0;
    while (got_n < TOTAL && wt < 20000) begin @(negedge ser_clk); wt++; end
    repeat (300) @(negedge ser_clk);
  endtask

  task automatic readout(input logic [7:0] id, input int tm, input bit resp,
                         input string req);
    int p0 [NP];
    for (int s = 0; s < NP; s++) p0[s] = pulses[s];
    got_n = 0; thr = tm;
    send_id(id);
    if (resp) wait_bytes();
    else repeat (300) @(negedge ser_clk);
    chk(got_n == (resp ? TOTAL : 0), req, "byte count", got_n, resp ? TOTAL : 0);
    check_pulses(p0, resp ? int'(id) : -1, req);
    if (resp && got_n >= TOTAL) check_bytes(int'(id), req);
  endtask

  initial begin
    int p0 [NP];
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(taken == '0, "R9", "read-enable during reset", int'(taken), 0);
    chk(tx_valid == 1'b0, "R9", "tx_valid during reset", int'(tx_valid), 0);
    @(posedge clk); #1 rst_n = 1; ser_rst_n = 1;
    // R9: read right after reset, older entries must be zero
    readout(8'd0, 0, 1'b1, "R9");
    chk(rx_ready == 1'b1, "R7", "rx_ready", int'(rx_ready), 1);

    // R1 R2 R3 R6 R8: table-driven readouts
    for (int v = 0; v < 8; v++) begin
      string tag;
      tag = VEC[v][0] ? (VEC[v][1] ? "R8" : "R6") : "R3";
      readout(VEC[v][9:2], int'(VEC[v][1]), VEC[v][0], tag);
    end

    // R7: selections during a transfer are dropped
    for (int s = 0; s < NP; s++) p0[s] = pulses[s];
    got_n = 0; thr = 1;
    send_id(8'd1);
    repeat (4) @(negedge ser_clk);
    send_id(8'd2);
    repeat (10) @(negedge ser_clk);
    send_id(8'd0);
    wait_bytes();
    chk(got_n == TOTAL, "R7", "byte count with busy drops", got_n, TOTAL);
    check_pulses(p0, 1, "R7");
    if (got_n >= TOTAL) check_bytes(1, "R5");
    // R7: accepted again after the last byte, R4 single pulse on slot 3
    readout(8'd3, 0, 1'b1, "R4");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R7 run did not complete: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule